// File: doc/BRIEF.md
# Programmable Angular Cam Switch

The block turns a raw angular position word into a vector of timing-channel outputs. Each raw sample is first scaled to a programmable number of divisions per revolution. A programmable offset is then added, and the sum wraps at the scale. Each channel compares the resulting position against its own program, in one of two modes:

- **Window mode.** The channel holds a list of on/off set-point pairs.
- **Pulse-train mode.** The channel repeats fixed on and off division counts from division zero across the whole revolution.

A small bank of programs is stored, and a select input picks the program used by the next sample.

All settings are loaded through a single-cycle register-write port: scale, offset, the set-point pairs and the per-channel modes. Window evaluation is a sequential scan. The scan takes one cycle per stored pair, with all channels in parallel. The output vector is registered when the scan completes.

Writes aimed at the program in use are held back until the next sample boundary. This keeps a running scan from ever seeing a half-edited program. Writes to any other program land at once.

Top module: `cam_switch`

## Requirements
- R1: The scaled position is floor(rawPos * scale / 2^16). A scale write (kind 0, pair field 0, value in wrData[12:0]) is accepted only for values 2 to 4096. Other values leave the scale unchanged. The scale after reset is 4096.
- R2: The effective position is (scaled + offset) mod scale. An offset write (kind 0, pair field 1, value in wrData[12:0]) is accepted only when the value is below the current scale; otherwise it is ignored. A scale write that leaves the offset at or above the new scale clears the offset to 0.
- R3: An enabled pair with on < off drives its channel high for on <= position < off. A pair with on == off never drives it high. A disabled pair has no effect.
- R4: An enabled pair with off < on wraps through zero. It is active when position >= on or position < off.
- R5: In window mode a channel output is the OR of all its PAIRS pairs (default 4), the last pair index included.
- R6: In pulse-train mode a channel is high when position mod (onLen + offLen) < onLen. It is low when onLen + offLen is 0.
- R7: A sample accepted at a clock edge updates chanOut exactly PAIRS clock edges later, and chanOut holds its value at every other edge.
- R8: A posValid pulse that arrives while a scan is in progress is ignored.
- R9: progSel is captured when a sample is accepted and selects the program for that sample's evaluation.
- R10: A write to the program in use is deferred to the next sample boundary. A write in the same cycle as an accepted sample applies to that sample.
- R11: A write to a program that is not in use takes effect immediately. It is seen by the first sample that selects that program.
- R12: After reset chanOut is 0, every pair is disabled, every channel is in window mode, and the offset is 0.
- R13: Write address = {kind[1:0], prog[2:0], chan[2:0], pair[1:0]} with the defaults. The kinds are 0 = config, 1 = pair and 2 = channel; kind 3 is ignored.
  - A pair write carries on in wrData[11:0], off in wrData[23:12] and enable in wrData[24].
  - A channel write carries onLen in wrData[11:0], offLen in wrData[23:12] and pulse mode in wrData[24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| posValid | input | 1 | New raw position sample strobe |
| rawPos | input | RAW_W (16) | Raw position word, full revolution = 2^RAW_W |
| progSel | input | PROG_AW (3) | Program to use for the next sample |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (10) | Write address {kind, prog, chan, pair} |
| wrData | input | 25 | Write data |
| chanOut | output | NUM_CH (8) | Timing-channel outputs |

## Verification
Two functions can fall in the same cycle: a register write to the program in use, and the acceptance of a position sample. The bench provokes this by raising wrEn and posValid on the same edge with a new pair for the active program. The result of that very sample must include the new window. A contrasting case places the write one cycle after acceptance. That result must exclude the window, and the following sample must include it.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int POS_W      = 12;
  localparam int SCALE_W    = POS_W + 1;
  localparam int MAX_PAIR_W = 6;
  localparam int WDATA_W    = 2 * POS_W + 1;
  localparam int SCALE_MAX  = 1 << POS_W;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_PAIR = 2'd1,
    KIND_CHAN = 2'd2,
    KIND_NONE = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic             en;
    logic [POS_W-1:0] offPt;
    logic [POS_W-1:0] onPt;
  } pair_t;

  typedef struct packed {
    logic             pulse;
    logic [POS_W-1:0] offLen;
    logic [POS_W-1:0] onLen;
  } chan_t;

  typedef struct packed {
    logic                  latch;
    logic                  eval;
    logic                  first;
    logic                  commit;
    logic [MAX_PAIR_W-1:0] pairIdx;
  } strobe_t;

  typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;

  function automatic logic inWindow(input logic [POS_W-1:0] pos, input pair_t p);
    logic r;
    if (!p.en)                r = 1'b0;
    else if (p.onPt < p.offPt) r = (pos >= p.onPt) && (pos < p.offPt);
    else if (p.offPt < p.onPt) r = (pos >= p.onPt) || (pos < p.offPt);
    else                       r = 1'b0;
    return r;
  endfunction

  function automatic logic pulseOn(input logic [POS_W-1:0] pos, input chan_t c);
    logic [SCALE_W-1:0] period;
    logic [SCALE_W:0]   rem;
    period = {1'b0, c.onLen} + {1'b0, c.offLen};
    rem = '0;
    for (int i = POS_W - 1; i >= 0; i--) begin
      rem = {rem[SCALE_W-1:0], pos[i]};
      if (rem >= {1'b0, period}) rem = rem - {1'b0, period};
    end
    return (period != '0) && (rem < {2'b00, c.onLen});
  endfunction
endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
#(
  parameter int PAIRS = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    posValid,
  output strobe_t strobes
);
  localparam logic [MAX_PAIR_W-1:0] LAST_IDX = MAX_PAIR_W'(PAIRS - 1);

  scan_st_e              state;
  logic [MAX_PAIR_W-1:0] pairCnt;

  always_comb begin
    strobes         = '0;
    strobes.pairIdx = pairCnt;
    if (state == ST_IDLE) begin
      strobes.latch = posValid;
    end else begin
      strobes.eval   = 1'b1;
      strobes.first  = (pairCnt == '0);
      strobes.commit = (pairCnt == LAST_IDX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pairCnt <= '0;
    end else if (state == ST_IDLE) begin
      pairCnt <= '0;
      if (posValid) state <= ST_SCAN;
    end else if (pairCnt == LAST_IDX) begin
      state   <= ST_IDLE;
      pairCnt <= '0;
    end else begin
      pairCnt <= pairCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int PAIRS    = 4,
  parameter int NUM_PROG = 8,
  parameter int RAW_W    = 16,
  parameter int PROG_AW  = 3,
  parameter int CH_AW    = 3,
  parameter int PAIR_AW  = 2,
  parameter int ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strobes,
  input  logic [RAW_W-1:0]    rawPos,
  input  logic [PROG_AW-1:0]  progSel,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WDATA_W-1:0]  wrData,
  output logic [NUM_CH-1:0]   chanOut,
  output logic [POS_W-1:0]    curPos,
  output logic [SCALE_W-1:0]  scaleReg,
  output logic [SCALE_W-1:0]  offsetReg
);
  localparam int PAIR_DEPTH = NUM_PROG * NUM_CH * PAIRS;
  localparam int CHAN_DEPTH = NUM_PROG * NUM_CH;
  localparam int PI_W       = $clog2(PAIR_DEPTH);
  localparam int CI_W       = $clog2(CHAN_DEPTH);
  localparam int PROD_W     = RAW_W + SCALE_W;

  pair_t stagePair [PAIR_DEPTH];
  pair_t livePair  [PAIR_DEPTH];
  chan_t stageChan [CHAN_DEPTH];
  chan_t liveChan  [CHAN_DEPTH];

  logic [PROG_AW-1:0] activeProg;
  logic [NUM_CH-1:0]  acc;
  logic [NUM_CH-1:0]  winHit;
  logic [NUM_CH-1:0]  pulseHit;
  logic [NUM_CH-1:0]  pulseMode;

  // write decode
  wr_kind_e           wKind;
  logic [PROG_AW-1:0] wProg;
  logic [CH_AW-1:0]   wChan;
  logic [PAIR_AW-1:0] wPair;
  logic               wTargetOk;
  logic               pairWr, chanWr, scaleWr, offsetWr, toLive;
  logic [PI_W-1:0]    pairWi;
  logic [CI_W-1:0]    chanWi;
  logic [SCALE_W-1:0] cfgVal;

  always_comb begin
    wKind     = wr_kind_e'(wrAddr[ADDR_W-1 -: 2]);
    wProg     = wrAddr[PAIR_AW + CH_AW +: PROG_AW];
    wChan     = wrAddr[PAIR_AW +: CH_AW];
    wPair     = wrAddr[0 +: PAIR_AW];
    cfgVal    = wrData[SCALE_W-1:0];
    wTargetOk = (int'(wProg) < NUM_PROG) && (int'(wChan) < NUM_CH);
    pairWr    = wrEn && (wKind == KIND_PAIR) && wTargetOk && (int'(wPair) < PAIRS);
    chanWr    = wrEn && (wKind == KIND_CHAN) && wTargetOk;
    scaleWr   = wrEn && (wKind == KIND_CFG) && (wPair == PAIR_AW'(0)) &&
                (cfgVal >= SCALE_W'(2)) && (cfgVal <= SCALE_W'(SCALE_MAX));
    offsetWr  = wrEn && (wKind == KIND_CFG) && (wPair == PAIR_AW'(1)) &&
                (cfgVal < scaleReg);
    toLive    = strobes.latch || (wProg != activeProg);
    pairWi    = PI_W'((int'(wProg) * NUM_CH + int'(wChan)) * PAIRS + int'(wPair));
    chanWi    = CI_W'(int'(wProg) * NUM_CH + int'(wChan));
  end

  // program storage: staging copy always written, live copy used by evaluation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAIR_DEPTH; i++) begin
        stagePair[i] <= '0;
        livePair[i]  <= '0;
      end
      for (int i = 0; i < CHAN_DEPTH; i++) begin
        stageChan[i] <= '0;
        liveChan[i]  <= '0;
      end
    end else begin
      if (strobes.latch) begin
        livePair <= stagePair;
        liveChan <= stageChan;
      end
      if (pairWr) begin
        stagePair[pairWi] <= pair_t'(wrData);
        if (toLive) livePair[pairWi] <= pair_t'(wrData);
      end
      if (chanWr) begin
        stageChan[chanWi] <= chan_t'(wrData);
        if (toLive) liveChan[chanWi] <= chan_t'(wrData);
      end
    end
  end

  // scale and offset registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scaleReg  <= SCALE_W'(SCALE_MAX);
      offsetReg <= '0;
    end else if (scaleWr) begin
      scaleReg <= cfgVal;
      if (offsetReg >= cfgVal) offsetReg <= '0;
    end else if (offsetWr) begin
      offsetReg <= cfgVal;
    end
  end

  function automatic logic [POS_W-1:0] wrapPos(input logic [RAW_W-1:0] raw,
                                               input logic [SCALE_W-1:0] sc,
                                               input logic [SCALE_W-1:0] off);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] sum;
    prod = PROD_W'(raw) * PROD_W'(sc);
    sum  = (prod >> RAW_W) + PROD_W'(off);
    if (sum >= PROD_W'(sc)) sum = sum - PROD_W'(sc);
    return sum[POS_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPos     <= '0;
      activeProg <= '0;
    end else if (strobes.latch) begin
      curPos     <= wrapPos(rawPos, scaleReg, offsetReg);
      activeProg <= progSel;
    end
  end

  // per-channel evaluation, one pair index per cycle for all channels
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pair_t curPair;
    chan_t curChan;
    always_comb begin
      curPair     = livePair[PI_W'((int'(activeProg) * NUM_CH + c) * PAIRS +
                                   int'(strobes.pairIdx))];
      curChan     = liveChan[CI_W'(int'(activeProg) * NUM_CH + c)];
      winHit[c]   = inWindow(curPos, curPair);
      pulseHit[c] = pulseOn(curPos, curChan);
      pulseMode[c] = curChan.pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      chanOut <= '0;
    end else if (strobes.eval) begin
      acc <= (strobes.first ? '0 : acc) | winHit;
      if (strobes.commit)
        chanOut <= (pulseMode & pulseHit) |
                   (~pulseMode & ((strobes.first ? '0 : acc) | winHit));
    end
  end
endmodule

// File: rtl/cam_switch.sv
module cam_switch
  import cam_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int PAIRS    = 4,
  parameter int NUM_PROG = 8,
  parameter int RAW_W    = 16,
  localparam int PROG_AW = $clog2(NUM_PROG),
  localparam int CH_AW   = $clog2(NUM_CH),
  localparam int PAIR_AW = $clog2(PAIRS),
  localparam int ADDR_W  = 2 + PROG_AW + CH_AW + PAIR_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               posValid,
  input  logic [RAW_W-1:0]   rawPos,
  input  logic [PROG_AW-1:0] progSel,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [WDATA_W-1:0] wrData,
  output logic [NUM_CH-1:0]  chanOut
);
  strobe_t            strobes;
  logic [POS_W-1:0]   curPos;
  logic [SCALE_W-1:0] scaleReg;
  logic [SCALE_W-1:0] offsetReg;

  cam_ctrl #(.PAIRS(PAIRS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .posValid(posValid), .strobes(strobes)
  );

  cam_datapath #(
    .NUM_CH(NUM_CH), .PAIRS(PAIRS), .NUM_PROG(NUM_PROG), .RAW_W(RAW_W),
    .PROG_AW(PROG_AW), .CH_AW(CH_AW), .PAIR_AW(PAIR_AW), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rawPos(rawPos),
    .progSel(progSel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chanOut(chanOut), .curPos(curPos), .scaleReg(scaleReg),
    .offsetReg(offsetReg)
  );
endmodule

// File: rtl/cam_checker.sv
module cam_checker
  import cam_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PAIRS  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               latch,
  input logic               commit,
  input logic [NUM_CH-1:0]  chanOut,
  input logic [POS_W-1:0]   curPos,
  input logic [SCALE_W-1:0] scaleReg,
  input logic [SCALE_W-1:0] offsetReg
);
  logic [MAX_PAIR_W:0] scanLeft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            scanLeft <= '0;
    else if (latch)        scanLeft <= (MAX_PAIR_W + 1)'(PAIRS);
    else if (scanLeft != 0) scanLeft <= scanLeft - 1'b1;
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (scanLeft == '0));

  assert_commit_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (scanLeft == (MAX_PAIR_W + 1)'(1)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chanOut) |-> $past(commit));

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(latch) |-> ({1'b0, curPos} < $past(scaleReg)));

  assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    offsetReg < scaleReg);

  assert_scale_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scaleReg >= SCALE_W'(2)) && (scaleReg <= SCALE_W'(SCALE_MAX)));

  assert_reset_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chanOut == '0));
endmodule

bind cam_switch cam_checker #(.NUM_CH(NUM_CH), .PAIRS(PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch(strobes.latch), .commit(strobes.commit),
  .chanOut(chanOut), .curPos(curPos), .scaleReg(scaleReg),
  .offsetReg(offsetReg)
);

// File: tb/test_cam_switch.sv
module test_cam_switch;
  localparam int PAIRS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        posValid = 1'b0;
  logic [15:0] rawPos = '0;
  logic [2:0]  progSel = '0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrAddr = '0;
  logic [24:0] wrData = '0;
  logic [7:0]  chanOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cam_switch i_cam_switch (
    .clk(clk), .rst_n(rst_n), .posValid(posValid), .rawPos(rawPos),
    .progSel(progSel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chanOut(chanOut)
  );

  typedef struct packed {
    logic [11:0] pos;
    logic [7:0]  exp;
  } vec_t;

  // program 0 at scale 360: ch0 windows 10..20,100..110; ch1 wrap 350..5;
  // ch2 pulse on 3 off 2; ch3 empty 50..50 and last pair 200..210
  localparam vec_t VECS [12] = '{
    '{12'd0,   8'h06}, '{12'd10,  8'h05}, '{12'd19,  8'h01},
    '{12'd20,  8'h04}, '{12'd50,  8'h04}, '{12'd104, 8'h01},
    '{12'd202, 8'h0C}, '{12'd350, 8'h06}, '{12'd359, 8'h02},
    '{12'd4,   8'h02}, '{12'd5,   8'h04}, '{12'd7,   8'h04}
  };

  function automatic logic [15:0] rawFor(input int pos, input int scale);
    longint v;
    v = (longint'(pos) * 65536 + scale - 1) / scale;
    return v[15:0];
  endfunction

  function automatic logic [9:0] mkAddr(input int kind, input int prog,
                                        input int ch, input int pair);
    return {kind[1:0], prog[2:0], ch[2:0], pair[1:0]};
  endfunction

  function automatic logic [24:0] mkData(input int a, input int b, input bit f);
    return {f, b[11:0], a[11:0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: chanOut=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int prog, input int ch, input int pair,
                    input logic [24:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = mkAddr(kind, prog, ch, pair); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sampleCheck(input logic [15:0] raw, input int sel,
                             input logic [7:0] exp, input string tag);
    @(negedge clk);
    posValid = 1'b1; rawPos = raw; progSel = sel[2:0];
    @(posedge clk);
    @(negedge clk);
    posValid = 1'b0;
    repeat (PAIRS) @(posedge clk);
    @(negedge clk);
    check(tag, chanOut, exp);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: chanOut=%h expected=done", chanOut);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset output", chanOut, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 layout: scale 360, offset 0, program 0 set-up
    wr(0, 0, 0, 0, 25'd360);
    wr(1, 0, 0, 0, mkData(10, 20, 1));
    wr(1, 0, 0, 1, mkData(100, 110, 1));
    wr(1, 0, 1, 0, mkData(350, 5, 1));
    wr(2, 0, 2, 0, mkData(3, 2, 1));
    wr(1, 0, 3, 0, mkData(50, 50, 1));
    wr(1, 0, 3, 3, mkData(200, 210, 1));
    wr(1, 0, 3, 1, mkData(30, 40, 0));

    for (int i = 0; i < 12; i++)
      sampleCheck(rawFor(int'(VECS[i].pos), 360), 0, VECS[i].exp,
                  $sformatf("R1 R3 R4 R5 R6 vector pos=%0d", VECS[i].pos));

    // R2 offset wrap
    wr(0, 0, 0, 1, 25'd340);
    sampleCheck(rawFor(30, 360), 0, 8'h05, "R2 offset wraps past scale");
    sampleCheck(rawFor(10, 360), 0, 8'h06, "R2 offset below scale");
    wr(0, 0, 0, 1, 25'd400);
    sampleCheck(rawFor(30, 360), 0, 8'h05, "R2 offset >= scale ignored");
    wr(0, 0, 0, 1, 25'd0);

    // R1 invalid scale values ignored
    wr(0, 0, 0, 0, 25'd1);
    wr(0, 0, 0, 0, 25'd4097);
    sampleCheck(rawFor(10, 360), 0, 8'h05, "R1 scale 1 and 4097 ignored");

    // R11 write to a program not in use, R9 program select at sample
    wr(1, 1, 5, 0, mkData(0, 300, 1));
    sampleCheck(rawFor(10, 360), 1, 8'h20, "R9 R11 select program 1");
    sampleCheck(rawFor(10, 360), 0, 8'h05, "R9 back to program 0");
    sampleCheck(rawFor(10, 360), 1, 8'h20, "R9 program 1 again");

    // R10 write to active program during a scan is deferred
    @(negedge clk);
    posValid = 1'b1; rawPos = rawFor(10, 360); progSel = 3'd1;
    @(posedge clk);
    @(negedge clk);
    posValid = 1'b0;
    wrEn = 1'b1; wrAddr = mkAddr(2, 1, 6, 0); wrData = mkData(1, 0, 1);
    @(negedge clk);
    wrEn = 1'b0;
    repeat (PAIRS - 1) @(posedge clk);
    @(negedge clk);
    check("R10 write during scan deferred", chanOut, 8'h20);
    sampleCheck(rawFor(10, 360), 1, 8'h60, "R10 deferred write applied");

    // R10 write in the same cycle as a sample applies to that sample
    @(negedge clk);
    posValid = 1'b1; rawPos = rawFor(10, 360); progSel = 3'd1;
    wrEn = 1'b1; wrAddr = mkAddr(1, 1, 4, 0); wrData = mkData(5, 15, 1);
    @(posedge clk);
    @(negedge clk);
    posValid = 1'b0; wrEn = 1'b0;
    repeat (PAIRS) @(posedge clk);
    @(negedge clk);
    check("R10 same-cycle write applied", chanOut, 8'h70);

    // R8 sample during scan ignored
    @(negedge clk);
    posValid = 1'b1; rawPos = rawFor(10, 360); progSel = 3'd1;
    @(posedge clk);
    @(negedge clk);
    rawPos = rawFor(350, 360);
    @(negedge clk);
    posValid = 1'b0;
    repeat (PAIRS - 1) @(posedge clk);
    @(negedge clk);
    check("R8 first sample result", chanOut, 8'h70);
    repeat (4) @(negedge clk);
    check("R8 second sample dropped", chanOut, 8'h70);

    // R7 exact latency
    @(negedge clk);
    posValid = 1'b1; rawPos = rawFor(350, 360); progSel = 3'd1;
    @(posedge clk);
    @(negedge clk);
    posValid = 1'b0;
    repeat (PAIRS - 1) @(posedge clk);
    @(negedge clk);
    check("R7 held before commit", chanOut, 8'h70);
    @(posedge clk);
    @(negedge clk);
    check("R7 updated at commit", chanOut, 8'h40);

    // R1 full scale 4096, R4 wrap at top
    wr(0, 0, 0, 0, 25'd4096);
    wr(1, 1, 7, 0, mkData(4000, 10, 1));
    sampleCheck(16'hFFFF, 1, 8'hC0, "R1 scale 4096 top position");
    sampleCheck(16'h0000, 1, 8'hE0, "R1 R4 scale 4096 position 0");

    // R1 R2 smallest scale
    wr(1, 0, 3, 1, mkData(1, 2, 1));
    wr(0, 0, 0, 0, 25'd2);
    sampleCheck(16'h0000, 0, 8'h06, "R1 scale 2 position 0");
    sampleCheck(16'h8000, 0, 8'h0E, "R1 scale 2 position 1");
    wr(0, 0, 0, 1, 25'd1);
    sampleCheck(16'h8000, 0, 8'h06, "R2 scale 2 offset wrap");
    sampleCheck(16'h0000, 0, 8'h0E, "R2 scale 2 offset 1");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule